// File: doc/BRIEF.md
# Level-Sensitive Prioritising Interrupt Controller

The block collects up to 128 level-sensitive request lines, arranged as one to four banks of 32, and presents them to a processor on two outputs: a normal interrupt and a fast interrupt. Each line carries a 6-bit priority and a route bit that sends it to one output or the other. When an output is armed and an unmasked pending line of its class exists, the controller picks the winner, latches its line number and raises the output. The output stays high until software writes the matching re-arm bit.

Software works through a 32-bit word register bus. Each write is one cycle, and a read is a combinational decode of the address. The bank masks and the software-forced request bits change through separate set and clear registers, so no read-modify-write is needed. For each bank, software can read the raw input levels and one pending vector per class. A system control register gives a global mask. A configuration register gives a soft reset that returns every register to its power-up value.

Top module: `lvl_intc`

## Requirements
- R1: After reset every mask bit is 1. Pending bits, software bits, priorities, route bits, the global mask and both latched line numbers are 0, and both outputs are low. Offset 0x00 reads 0x21 and offset 0x14 reads 1.
- R2: Bit 0 of offset 0x10 is an auto-idle flag that reads back. Offset 0x50 holds a 2-bit idle field, bits [1:0], that reads back. Offset 0x4C reads 0, and writes to it have no effect.
- R3: The register at bank base + 0x00 returns the request levels captured at the previous clock edge. A request that was low at that edge and is high now sets its pending bit on this edge. Bank base is 0x80 + 0x20 × bank.
- R4: When any request of a bank falls, the whole pending word of that bank becomes the current request levels OR that bank's software bits.
- R5: A write to bank base + 0x10 ORs the data into both the software bits and the pending bits, and reads of that offset return the software bits. A write to bank base + 0x14 clears the software bits given by the data and then sets that bank's pending word to the new software bits AND the captured input levels.
- R6: Bank base + 0x04 writes the whole mask, bank base + 0x08 clears the mask bits set in the data, and bank base + 0x0C sets them. Bank base + 0x04 reads the mask.
- R7: Bank base + 0x18 reads pending AND NOT mask AND NOT route. Bank base + 0x1C reads pending AND NOT mask AND route.
- R8: Among the eligible lines of a class, the one with the smallest priority value wins. On equal values the higher line number wins. The winner's number is latched when the output rises, and offsets 0x40 (normal) and 0x44 (fast) read it.
- R9: An armed output with at least one eligible line rises on the next edge and disarms. Writing offset 0x48 with bit 0 (normal) or bit 1 (fast) set drops that output on that edge and re-arms it. An output that has risen stays high until it is re-armed.
- R10: Offset 0x48 bit 2 is the global mask. While it is 1 no output can rise, and it reads back at bit 2.
- R11: Reading offsets 0x40 and 0x44 changes no state.
- R12: Writing offset 0x10 with bit 1 set returns every register to its R1 state on that edge. Captured inputs are cleared, so a request that is still high re-enters as a rising request.
- R13: The line register at 0x100 + 4 × line holds the priority in bits [7:2] and the route bit in bit 0. Route 1 selects the fast class.
- R14: Writes to read-only or undefined offsets change nothing. Reads of undefined offsets return 0, and this includes the bank registers of banks that are not present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_in | input | 32*NBANK | Level request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The hardest state to reach is a software-bit clear that leaves a bank's pending word smaller than its request levels. In that state a line stays high but is no longer pending. Only a later fall of some other line in the bank brings it back. The random phase mixes request toggles with software set and clear writes and mask writes on both banks, and it compares every pending read against a bench model. The phase also re-arms the normal output at intervals under random priorities, so that the priority resolution and the highest-line tie-break are checked on many different eligible sets.

// File: rtl/lvl_intc.sv
`timescale 1ns/1ps
module lvl_intc #(
  parameter int NBANK  = 2,
  parameter int PRIO_W = 6,
  parameter int AW     = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [32*NBANK-1:0]   req_in,
  input  logic                  bus_wr,
  input  logic [AW-1:0]         bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  irq_o,
  output logic                  fiq_o
);
  localparam int NLINE = 32 * NBANK;
  localparam int IW    = $clog2(NLINE);

  logic [NLINE-1:0]  in_q, pend_q, swi_q, mask_q, fast_q;
  logic [NLINE-1:0]  pend_d, swi_d, mask_d;
  logic [PRIO_W-1:0] prio_q [NLINE];
  logic              gmask_q, aidle_q, arm_n_q, arm_f_q, irq_q, fiq_q;
  logic [1:0]        idle_q;
  logic [IW-1:0]     sir_n_q, sir_f_q, win_n, win_f;
  logic [PRIO_W-1:0] best_n, best_f;

  wire sreset  = bus_wr && bus_addr == AW'(12'h010) && bus_wdata[1];
  wire ctl_wr  = bus_wr && bus_addr == AW'(12'h048);
  wire [1:0] bsel = bus_addr[6:5];
  wire [2:0] breg = bus_addr[4:2];
  wire bank_hit = bus_addr[AW-1:7] == (AW-7)'(1) && bus_addr[1:0] == 2'b00 &&
                  int'(bsel) < NBANK;
  wire [AW-1:0] ilr_off = bus_addr - AW'(12'h100);
  wire ilr_hit = bus_addr >= AW'(12'h100) && bus_addr < AW'(256 + 4 * NLINE) &&
                 bus_addr[1:0] == 2'b00;
  wire [IW-1:0] ilr_idx = ilr_off[IW+1:2];

  wire [NLINE-1:0] elig_n = pend_q & ~mask_q & ~fast_q;
  wire [NLINE-1:0] elig_f = pend_q & ~mask_q & fast_q;
  wire [NLINE-1:0] rise   = req_in & ~in_q;
  wire [NLINE-1:0] fall   = ~req_in & in_q;

  always_comb begin
    swi_d  = swi_q;
    mask_d = mask_q;
    pend_d = pend_q;
    for (int b = 0; b < NBANK; b++) begin
      if (bus_wr && bank_hit && int'(bsel) == b) begin
        case (breg)
          3'd1: mask_d[b*32 +: 32] = bus_wdata;
          3'd2: mask_d[b*32 +: 32] = mask_q[b*32 +: 32] & ~bus_wdata;
          3'd3: mask_d[b*32 +: 32] = mask_q[b*32 +: 32] | bus_wdata;
          3'd4: begin
            swi_d[b*32 +: 32]  = swi_q[b*32 +: 32] | bus_wdata;
            pend_d[b*32 +: 32] = pend_q[b*32 +: 32] | bus_wdata;
          end
          3'd5: begin
            swi_d[b*32 +: 32]  = swi_q[b*32 +: 32] & ~bus_wdata;
            pend_d[b*32 +: 32] = swi_d[b*32 +: 32] & in_q[b*32 +: 32];
          end
          default: ;
        endcase
      end
    end
    pend_d = pend_d | rise;
    for (int b = 0; b < NBANK; b++)
      if (|fall[b*32 +: 32])
        pend_d[b*32 +: 32] = req_in[b*32 +: 32] | swi_d[b*32 +: 32];
  end

  always_comb begin
    best_n = '1; best_f = '1; win_n = '0; win_f = '0;
    for (int i = 0; i < NLINE; i++) begin
      if (elig_n[i] && prio_q[i] <= best_n) begin best_n = prio_q[i]; win_n = IW'(i); end
      if (elig_f[i] && prio_q[i] <= best_f) begin best_f = prio_q[i]; win_f = IW'(i); end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sreset) begin
      in_q <= '0; pend_q <= '0; swi_q <= '0; mask_q <= '1; fast_q <= '0;
      for (int i = 0; i < NLINE; i++) prio_q[i] <= '0;
      gmask_q <= 1'b0; aidle_q <= 1'b0; idle_q <= 2'b00;
      arm_n_q <= 1'b1; arm_f_q <= 1'b1; irq_q <= 1'b0; fiq_q <= 1'b0;
      sir_n_q <= '0; sir_f_q <= '0;
    end else begin
      in_q   <= req_in;
      pend_q <= pend_d;
      swi_q  <= swi_d;
      mask_q <= mask_d;
      if (bus_wr && bus_addr == AW'(12'h010)) aidle_q <= bus_wdata[0];
      if (bus_wr && bus_addr == AW'(12'h050)) idle_q  <= bus_wdata[1:0];
      if (bus_wr && ilr_hit) begin
        prio_q[ilr_idx] <= bus_wdata[PRIO_W+1:2];
        fast_q[ilr_idx] <= bus_wdata[0];
      end
      if (arm_n_q && |elig_n && !gmask_q) begin
        irq_q <= 1'b1; arm_n_q <= 1'b0; sir_n_q <= win_n;
      end
      if (arm_f_q && |elig_f && !gmask_q) begin
        fiq_q <= 1'b1; arm_f_q <= 1'b0; sir_f_q <= win_f;
      end
      if (ctl_wr) begin
        gmask_q <= bus_wdata[2];
        if (bus_wdata[0]) begin irq_q <= 1'b0; arm_n_q <= 1'b1; end
        if (bus_wdata[1]) begin fiq_q <= 1'b0; arm_f_q <= 1'b1; end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(12'h000): bus_rdata = 32'h21;
      AW'(12'h010): bus_rdata = {31'b0, aidle_q};
      AW'(12'h014): bus_rdata = 32'h1;
      AW'(12'h040): bus_rdata = 32'(sir_n_q);
      AW'(12'h044): bus_rdata = 32'(sir_f_q);
      AW'(12'h048): bus_rdata = {29'b0, gmask_q, 2'b00};
      AW'(12'h050): bus_rdata = {30'b0, idle_q};
      default: ;
    endcase
    if (bank_hit) begin
      case (breg)
        3'd0: bus_rdata = in_q[int'(bsel)*32 +: 32];
        3'd1: bus_rdata = mask_q[int'(bsel)*32 +: 32];
        3'd4: bus_rdata = swi_q[int'(bsel)*32 +: 32];
        3'd6: bus_rdata = elig_n[int'(bsel)*32 +: 32];
        3'd7: bus_rdata = elig_f[int'(bsel)*32 +: 32];
        default: ;
      endcase
    end
    if (ilr_hit)
      bus_rdata = {{(30-PRIO_W){1'b0}}, prio_q[ilr_idx], 1'b0, fast_q[ilr_idx]};
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;
endmodule

// File: rtl/lvl_intc_chk.sv
`timescale 1ns/1ps
module lvl_intc_chk #(
  parameter int NL = 64,
  parameter int IW = 6,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          irq_o,
  input logic          gmask_q,
  input logic [IW-1:0] sir_n_q,
  input logic [NL-1:0] pend_q
);
  wire sreset = bus_wr && bus_addr == AW'(12'h010) && bus_wdata[1];
  wire rearm  = bus_wr && bus_addr == AW'(12'h048) && bus_wdata[0];

  a_r9_output_holds: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !rearm && !sreset |=> irq_o);

  a_r9_rearm_drops: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !irq_o);

  a_r10_gmask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !$past(gmask_q));

  a_r8_code_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(irq_o) && !$past(sreset) |-> $stable(sir_n_q));

  a_r5_swi_set_pends: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'(12'h090) |=>
      (pend_q[31:0] & $past(bus_wdata)) == $past(bus_wdata));
endmodule

bind lvl_intc lvl_intc_chk #(.NL(NLINE), .IW(IW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_o(irq_o), .gmask_q(gmask_q),
  .sir_n_q(sir_n_q), .pend_q(pend_q));

// File: tb/sim_lvl_intc.sv
`timescale 1ns/1ps
module sim_lvl_intc;
  logic        clk = 1'b0, rst_n = 1'b0, bwr = 1'b0;
  logic [63:0] req = '0;
  logic [11:0] badr = '0;
  logic [31:0] bwd = '0, brd;
  logic        irq, fiq;
  int          nchk = 0, nerr = 0;
  logic [31:0] v;
  logic        si, sf;

  logic [63:0] m_in, m_pend, m_swi, m_mask, m_fast;
  logic [5:0]  m_prio [64];

  lvl_intc #(.NBANK(2), .PRIO_W(6), .AW(12)) u0 (
    .clk(clk), .rst_n(rst_n), .req_in(req), .bus_wr(bwr), .bus_addr(badr),
    .bus_wdata(bwd), .bus_rdata(brd), .irq_o(irq), .fiq_o(fiq));

  always #10 clk = ~clk;

  initial begin
    #4000000;
    nerr++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  task automatic mreset();
    m_in = '0; m_pend = '0; m_swi = '0; m_mask = '1; m_fast = '0;
    for (int i = 0; i < 64; i++) m_prio[i] = '0;
  endtask

  task automatic mstep(input logic w, input logic [11:0] a, input logic [31:0] d);
    logic [63:0] sw, mk, p, rs, fl;
    int b, s;
    sw = m_swi; mk = m_mask; p = m_pend;
    if (!rst_n || (w && a == 12'h010 && d[1])) begin mreset(); return; end
    if (w && a >= 12'h080 && a < 12'h0C0 && a[1:0] == 0) begin
      b = (a - 12'h080) >> 5; s = a & 12'h1F;
      case (s)
        'h04: mk[b*32 +: 32] = d;
        'h08: mk[b*32 +: 32] &= ~d;
        'h0C: mk[b*32 +: 32] |= d;
        'h10: begin sw[b*32 +: 32] |= d; p[b*32 +: 32] |= d; end
        'h14: begin sw[b*32 +: 32] &= ~d; p[b*32 +: 32] = sw[b*32 +: 32] & m_in[b*32 +: 32]; end
        default: ;
      endcase
    end
    if (w && a >= 12'h100 && a < 12'h200 && a[1:0] == 0) begin
      m_prio[(a - 12'h100) >> 2] = d[7:2];
      m_fast[(a - 12'h100) >> 2] = d[0];
    end
    rs = req & ~m_in; fl = ~req & m_in;
    p |= rs;
    for (int k = 0; k < 2; k++) if (|fl[k*32 +: 32]) p[k*32 +: 32] = req[k*32 +: 32] | sw[k*32 +: 32];
    m_in = req; m_pend = p; m_swi = sw; m_mask = mk;
  endtask

  task automatic cyc(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bwr = w; badr = a; bwd = d;
    #1 v = brd; si = irq; sf = fiq;
    @(posedge clk);
    mstep(w, a, d);
    #1 bwr = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d); cyc(1'b1, a, d); endtask
  task automatic rd(input logic [11:0] a); cyc(1'b0, a, 32'h0); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) cyc(1'b0, 12'h0, 32'h0); endtask
  task automatic setreq(input logic [63:0] r); @(negedge clk); req = r; cyc(1'b0, 12'h0, 32'h0); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_win(input logic fsel);
    int w; logic [6:0] best;
    w = -1; best = 7'd64;
    for (int i = 0; i < 64; i++)
      if (m_pend[i] && !m_mask[i] && (m_fast[i] == fsel) && {1'b0, m_prio[i]} <= best) begin
        best = {1'b0, m_prio[i]}; w = i;
      end
    return w;
  endfunction

  function automatic logic [31:0] exp_bank(input int b, input int s);
    case (s)
      0: return m_in[b*32 +: 32];
      1: return m_mask[b*32 +: 32];
      4: return m_swi[b*32 +: 32];
      6: return (m_pend & ~m_mask & ~m_fast) >> (b*32);
      7: return (m_pend & ~m_mask & m_fast) >> (b*32);
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    mreset();
    cyc(1'b0, 12'h0, 32'h0); cyc(1'b0, 12'h0, 32'h0); cyc(1'b0, 12'h0, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    rd(12'h000); chk("R1 id", v, 32'h21);
    rd(12'h014); chk("R1 status", v, 32'h1);
    rd(12'h084); chk("R1 mask", v, 32'hFFFFFFFF);
    rd(12'h0B8); chk("R1 pend bank1", v, 32'h0);
    chk("R1 outputs", {30'b0, si, sf}, 32'h0);

    wr(12'h000, 32'h55); rd(12'h000); chk("R14 id write ignored", v, 32'h21);
    wr(12'h04C, 32'h1);  rd(12'h04C); chk("R2 protection reads 0", v, 32'h0);
    rd(12'h0C0); chk("R14 absent bank", v, 32'h0);
    rd(12'h020); chk("R14 undefined", v, 32'h0);
    wr(12'h010, 32'h1);  rd(12'h010); chk("R2 autoidle", v, 32'h1);
    wr(12'h050, 32'h6);  rd(12'h050); chk("R2 idle field", v, 32'h2);

    wr(12'h088, 32'hFFFF00FF); rd(12'h084); chk("R6 mask clear", v, 32'h0000FF00);
    wr(12'h08C, 32'h0000000F); rd(12'h084); chk("R6 mask set", v, 32'h0000FF0F);
    wr(12'h084, 32'h0); rd(12'h084); chk("R6 mask write", v, 32'h0);
    wr(12'h0A8, 32'hFFFFFFFF); rd(12'h0A4); chk("R6 bank1 clear", v, 32'h0);

    setreq(64'h20);
    rd(12'h080); chk("R3 raw inputs", v, 32'h20);
    rd(12'h098); chk("R7 pending normal", v, 32'h20);
    chk("R9 irq raised", {31'b0, si}, 32'h1);
    rd(12'h040); chk("R8 code line5", v, 32'd5);

    setreq(64'h0000_0100_0000_0020);
    idle(1);
    rd(12'h040); chk("R9 no change while disarmed", v, 32'd5);
    wr(12'h048, 32'h1);
    rd(12'h040); chk("R9 rearm drops irq", {31'b0, si}, 32'h0);
    rd(12'h040); chk("R8 tie goes to higher line", v, 32'd40);

    wr(12'h1A0, 32'h28); rd(12'h1A0); chk("R13 line reg", v, 32'h28);
    wr(12'h048, 32'h1); idle(1);
    rd(12'h040); chk("R8 lower value wins", v, 32'd5);
    rd(12'h040); chk("R11 code stable", v, 32'd5);
    chk("R11 irq kept", {31'b0, si}, 32'h1);

    wr(12'h11C, 32'h1);
    setreq(64'h0000_0100_0000_00A0);
    idle(1);
    rd(12'h044); chk("R8 fast code", v, 32'd7);
    chk("R9 fiq raised", {31'b0, sf}, 32'h1);
    rd(12'h09C); chk("R7 pending fast", v, 32'h80);
    rd(12'h098); chk("R7 normal excludes fast", v, 32'h20);

    wr(12'h048, 32'h5); idle(2);
    rd(12'h048); chk("R10 gmask readback", v, 32'h4);
    chk("R10 irq blocked", {31'b0, si}, 32'h0);
    wr(12'h048, 32'h0); idle(1);
    rd(12'h040); chk("R10 irq after unmask", {31'b0, si}, 32'h1);

    setreq(64'h0000_0100_0000_0080);
    rd(12'h098); chk("R4 fall clears pending", v, 32'h0);
    wr(12'h090, 32'h8);
    rd(12'h090); chk("R5 swi readback", v, 32'h8);
    rd(12'h098); chk("R5 swi pends", v, 32'h8);
    wr(12'h094, 32'h8);
    rd(12'h09C); chk("R5 clear drops held line", v, 32'h0);
    rd(12'h080); chk("R5 input still high", v, 32'h80);
    setreq(64'h0000_0000_0000_0080);
    rd(12'h09C); chk("R4 bank1 fall leaves bank0", v, 32'h0);
    setreq(64'h0000_0000_0000_0000);
    setreq(64'h0000_0000_0000_0080);
    rd(12'h09C); chk("R4 rerise pends", v, 32'h80);

    wr(12'h010, 32'h2);
    rd(12'h084); chk("R12 mask restored", v, 32'hFFFFFFFF);
    rd(12'h1A0); chk("R12 line reg cleared", v, 32'h0);
    rd(12'h010); chk("R12 autoidle cleared", v, 32'h0);
    rd(12'h050); chk("R12 idle cleared", v, 32'h0);
    chk("R12 outputs low", {30'b0, si, sf}, 32'h0);
    wr(12'h088, 32'hFFFFFFFF);
    rd(12'h09C); chk("R12 held line reenters", v, 32'h0);
    rd(12'h098); chk("R12 held line pends normal", v, 32'h80);

    for (int it = 0; it < 600; it++) begin
      int op, b;
      op = $urandom_range(0, 5);
      b  = $urandom_range(0, 1);
      case (op)
        0: setreq({$urandom, $urandom} & {$urandom, $urandom});
        1: wr(12'h080 + 12'(b*32) + 12'(4 * $urandom_range(1, 5)), $urandom & $urandom);
        2: wr(12'h100 + 12'(4 * $urandom_range(0, 63)), $urandom & 32'hFD);
        3: wr(12'h090 + 12'(b*32), 32'h1 << $urandom_range(0, 31));
        default: idle(1);
      endcase
      for (int s = 0; s < 8; s++) begin
        if (s == 0 || s == 1 || s == 4 || s == 6 || s == 7) begin
          rd(12'h080 + 12'(b*32) + 12'(4*s));
          chk($sformatf("R7 random bank%0d reg%0d", b, s), v, exp_bank(b, s));
        end
      end
      if (it % 25 == 24) begin
        int w;
        wr(12'h048, 32'h3);
        idle(1);
        w = exp_win(1'b0);
        rd(12'h040);
        if (w < 0) chk("R9 random no eligible", {31'b0, si}, 32'h0);
        else begin
          chk("R9 random irq", {31'b0, si}, 32'h1);
          chk("R8 random winner", v, 32'(w));
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule